// File: doc/BRIEF.md
# Single-Steppable Binary GCD Engine

This block finds the greatest common divisor of two unsigned operands with the binary method. First it strips common factors of two while it reduces the pair by halving and subtraction. Then it restores those factors by repeated doubling. A four-state controller sequences the work. Leaving the idle state and leaving the finished state each need a one-cycle start/acknowledge pulse. Every reduction or restoration iteration needs a one-cycle step pulse, so an operator or a supervising engine can walk the algorithm one iteration at a time.

The working pair, the count of common factors of two that were removed, the result register and a one-hot state code are all visible on the ports. An observer can follow each iteration as it happens. After a result is acknowledged, the block returns to idle and keeps its registers until the next start.

Top module: `gcd_stepper`

## Requirements
- R1: When `rst_n` is low at a clock edge, the state code becomes idle (4'b0001), and the working pair, the factor counter and the result all become zero.
- R2: In idle, a step pulse has no effect. A start pulse with both operands non-zero loads `a_in` into A and `b_in` into B, clears the counter and the result, and moves to reduce (4'b0010).
- R3: A start pulse in idle with either operand zero moves straight to finished (4'b1000) with a result of zero.
- R4: In reduce and in restore (4'b0100), a cycle without a step pulse changes no output.
- R5: A reduce step with A not equal to B applies the first rule that matches. If both are even, halve both and add one to the counter. If only A is even, halve A. If only B is even, halve B. Otherwise subtract the smaller value from the larger.
- R6: A reduce step with A equal to B copies A into the result and moves to restore, leaving A, B and the counter unchanged.
- R7: A restore step with a non-zero counter doubles the result and subtracts one from the counter. A restore step with a zero counter moves to finished and changes no register.
- R8: Finished holds every output until a start pulse, which returns the block to idle.
- R9: A start pulse during reduce or restore is ignored.
- R10: For non-zero operands, the result on reaching finished equals the greatest common divisor of the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 8 | First operand |
| b_in | input | 8 | Second operand |
| start_ack | input | 1 | One-cycle pulse: start from idle, acknowledge from finished |
| step | input | 1 | One-cycle pulse that advances one iteration |
| a_q | output | 8 | Working value A |
| b_q | output | 8 | Working value B |
| pow2_cnt | output | 6 | Count of common factors of two still to restore |
| gcd_out | output | 8 | Result register |
| state_oh | output | 4 | One-hot state: idle 0001, reduce 0010, restore 0100, finished 1000 |

## Verification
The properties assume that `a_in` and `b_in` are held steady across the start pulse that loads them. They do not assume that pulses are one cycle wide, so a held step or start only moves the block several iterations. The stimulus still drives every pulse for exactly one cycle from the falling edge, changes operands only while the block is idle, and sometimes raises start during reduce so that the ignore rule is exercised. Expected results come from a remainder-based divisor search in the bench, which shares no arithmetic with the binary method.

// File: rtl/gcd_pkg.sv
// Shared types for the stepped GCD engine.
// Assumes the one-hot state codes are the values seen on the state port.
package gcd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'b0001,
        ST_REDUCE  = 4'b0010,
        ST_RESTORE = 4'b0100,
        ST_FIN     = 4'b1000
    } gcd_state_e;

    typedef enum logic [2:0] {
        CMD_HOLD,
        CMD_LOAD,
        CMD_ZERO,
        CMD_REDUCE,
        CMD_LATCH,
        CMD_DOUBLE
    } gcd_cmd_e;

endpackage

// File: rtl/gcd_ctrl.sv
// Sequencer for the stepped GCD engine: holds the one-hot state and issues
// one datapath command per cycle.
// Assumes the status flags describe the registers as they are in this cycle.
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ack,
    input  logic       step,
    input  logic       op_zero,
    input  logic       pair_eq,
    input  logic       cnt_zero,
    output gcd_state_e state,
    output gcd_cmd_e   cmd
);

    gcd_state_e state_nx;

    // Choose the next state and the datapath command.
    always_comb begin
        state_nx = state;
        cmd      = CMD_HOLD;
        unique case (state)
            ST_IDLE: begin
                if (start_ack) begin
                    if (op_zero) begin
                        cmd      = CMD_ZERO;
                        state_nx = ST_FIN;
                    end else begin
                        cmd      = CMD_LOAD;
                        state_nx = ST_REDUCE;
                    end
                end
            end
            ST_REDUCE: begin
                if (step) begin
                    if (pair_eq) begin
                        cmd      = CMD_LATCH;
                        state_nx = ST_RESTORE;
                    end else begin
                        cmd = CMD_REDUCE;
                    end
                end
            end
            ST_RESTORE: begin
                if (step) begin
                    if (cnt_zero) state_nx = ST_FIN;
                    else          cmd      = CMD_DOUBLE;
                end
            end
            ST_FIN: begin
                if (start_ack) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/gcd_reduce.sv
// One binary-GCD reduction iteration, purely combinational.
// Assumes the caller uses the result only when the pair is unequal.
module gcd_reduce #(
    parameter int W  = 8,
    parameter int CW = 6
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  a_nx,
    output logic [W-1:0]  b_nx,
    output logic [CW-1:0] cnt_nx
);

    logic a_even, b_even, a_big;

    // Classify the pair: parity of each value and which one is larger.
    always_comb begin
        a_even = ~a[0];
        b_even = ~b[0];
        a_big  = (a > b);
    end

    // Apply the first matching reduction rule.
    always_comb begin
        a_nx   = a;
        b_nx   = b;
        cnt_nx = cnt;
        if (a_even && b_even) begin
            a_nx   = a >> 1;
            b_nx   = b >> 1;
            cnt_nx = cnt + 1'b1;
        end else if (a_even) begin
            a_nx = a >> 1;
        end else if (b_even) begin
            b_nx = b >> 1;
        end else if (a_big) begin
            a_nx = a - b;
        end else begin
            b_nx = b - a;
        end
    end

endmodule

// File: rtl/gcd_dp.sv
// Datapath for the stepped GCD engine: working pair, factor counter and
// result, updated by one command per cycle.
// Assumes CW is wide enough to count W halvings.
module gcd_dp
    import gcd_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  gcd_cmd_e      cmd,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    output logic [W-1:0]  a_q,
    output logic [W-1:0]  b_q,
    output logic [CW-1:0] cnt_q,
    output logic [W-1:0]  res_q,
    output logic          op_zero,
    output logic          pair_eq,
    output logic          cnt_zero
);

    localparam logic [CW-1:0] CNT_CLR = '0;
    localparam logic [W-1:0]  VAL_CLR = '0;

    logic [W-1:0]  a_red, b_red;
    logic [CW-1:0] cnt_red;

    gcd_reduce #(.W(W), .CW(CW)) u_reduce (
        .a      (a_q),
        .b      (b_q),
        .cnt    (cnt_q),
        .a_nx   (a_red),
        .b_nx   (b_red),
        .cnt_nx (cnt_red)
    );

    // Status flags that the sequencer reads.
    always_comb begin
        op_zero  = (a_in == VAL_CLR) || (b_in == VAL_CLR);
        pair_eq  = (a_q == b_q);
        cnt_zero = (cnt_q == CNT_CLR);
    end

    // Register update for each command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= VAL_CLR;
            b_q   <= VAL_CLR;
            cnt_q <= CNT_CLR;
            res_q <= VAL_CLR;
        end else begin
            unique case (cmd)
                CMD_LOAD, CMD_ZERO: begin
                    a_q   <= a_in;
                    b_q   <= b_in;
                    cnt_q <= CNT_CLR;
                    res_q <= VAL_CLR;
                end
                CMD_REDUCE: begin
                    a_q   <= a_red;
                    b_q   <= b_red;
                    cnt_q <= cnt_red;
                end
                CMD_LATCH:  res_q <= a_q;
                CMD_DOUBLE: begin
                    res_q <= res_q << 1;
                    cnt_q <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gcd_stepper.sv
// Top of the stepped GCD engine: joins the sequencer and the datapath.
// Assumes start_ack and step are single-cycle pulses that are already
// synchronous to clk.
module gcd_stepper
    import gcd_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic          start_ack,
    input  logic          step,
    output logic [W-1:0]  a_q,
    output logic [W-1:0]  b_q,
    output logic [CW-1:0] pow2_cnt,
    output logic [W-1:0]  gcd_out,
    output logic [3:0]    state_oh
);

    gcd_state_e state;
    gcd_cmd_e   cmd;
    logic       op_zero, pair_eq, cnt_zero;

    gcd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ack (start_ack),
        .step      (step),
        .op_zero   (op_zero),
        .pair_eq   (pair_eq),
        .cnt_zero  (cnt_zero),
        .state     (state),
        .cmd       (cmd)
    );

    gcd_dp #(.W(W), .CW(CW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .a_in     (a_in),
        .b_in     (b_in),
        .a_q      (a_q),
        .b_q      (b_q),
        .cnt_q    (pow2_cnt),
        .res_q    (gcd_out),
        .op_zero  (op_zero),
        .pair_eq  (pair_eq),
        .cnt_zero (cnt_zero)
    );

    // Present the state as its one-hot code.
    always_comb state_oh = state;

endmodule

// File: rtl/gcd_stepper_chk.sv
// Property checker for the stepped GCD engine, attached by bind.
// Assumes the operands are steady across the start pulse that loads them.
module gcd_stepper_chk #(
    parameter int W  = 8,
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  a_in,
    input logic [W-1:0]  b_in,
    input logic          start_ack,
    input logic          step,
    input logic [W-1:0]  a_q,
    input logic [W-1:0]  b_q,
    input logic [CW-1:0] pow2_cnt,
    input logic [W-1:0]  gcd_out,
    input logic [3:0]    state_oh
);

    localparam logic [3:0] S_IDLE = 4'b0001;
    localparam logic [3:0] S_RED  = 4'b0010;
    localparam logic [3:0] S_RES  = 4'b0100;
    localparam logic [3:0] S_FIN  = 4'b1000;

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_IDLE && !start_ack) |=> state_oh == S_IDLE);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_IDLE && start_ack && a_in != '0 && b_in != '0)
        |=> (state_oh == S_RED && a_q == $past(a_in) && b_q == $past(b_in)
             && pow2_cnt == '0));

    p_zero_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_IDLE && start_ack && (a_in == '0 || b_in == '0))
        |=> (state_oh == S_FIN && gcd_out == '0));

    p_no_step_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_oh == S_RED || state_oh == S_RES) && !step)
        |=> ($stable(a_q) && $stable(b_q) && $stable(pow2_cnt)
             && $stable(gcd_out) && $stable(state_oh)));

    p_both_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_RED && step && a_q != b_q && !a_q[0] && !b_q[0])
        |=> pow2_cnt == $past(pow2_cnt) + 1'b1);

    p_reduce_shrinks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_RED && step && a_q != b_q)
        |=> (a_q <= $past(a_q) && b_q <= $past(b_q)
             && (a_q != $past(a_q) || b_q != $past(b_q))));

    p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_RED && step && a_q == b_q)
        |=> (state_oh == S_RES && gcd_out == $past(a_q)));

    p_double_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_RES && step && pow2_cnt != '0)
        |=> (gcd_out == ($past(gcd_out) << 1)
             && pow2_cnt == $past(pow2_cnt) - 1'b1));

    p_restore_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_RES && step && pow2_cnt == '0)
        |=> (state_oh == S_FIN && $stable(gcd_out)));

    p_fin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_FIN && !start_ack)
        |=> (state_oh == S_FIN && $stable(gcd_out)));

    p_fin_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh == S_FIN && start_ack) |=> state_oh == S_IDLE);

    p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_oh == S_RED || state_oh == S_RES) && start_ack && !step)
        |=> $stable(state_oh));

endmodule

bind gcd_stepper gcd_stepper_chk #(.W(W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .b_in      (b_in),
    .start_ack (start_ack),
    .step      (step),
    .a_q       (a_q),
    .b_q       (b_q),
    .pow2_cnt  (pow2_cnt),
    .gcd_out   (gcd_out),
    .state_oh  (state_oh)
);

// File: tb/gcd_stepper_test.sv
`timescale 1ns/1ps
module gcd_stepper_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic       start_ack = 1'b0, step = 1'b0;
    logic [7:0] a_q, b_q, gcd_out;
    logic [5:0] pow2_cnt;
    logic [3:0] state_oh;

    int total = 0;
    int bad   = 0;
    int exp_q[$];
    logic [3:0] prev_state = 4'b0001;

    always #2.5 clk = ~clk;

    gcd_stepper uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_in      (a_in),
        .b_in      (b_in),
        .start_ack (start_ack),
        .step      (step),
        .a_q       (a_q),
        .b_q       (b_q),
        .pow2_cnt  (pow2_cnt),
        .gcd_out   (gcd_out),
        .state_oh  (state_oh)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_gcd(input int x, input int y);
        int p = x;
        int q = y;
        if (x == 0 || y == 0) return 0;
        while (q != 0) begin
            int t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    task automatic pulse_start();
        @(negedge clk) start_ack = 1'b1;
        @(negedge clk) start_ack = 1'b0;
    endtask

    task automatic pulse_step();
        @(negedge clk) step = 1'b1;
        @(negedge clk) step = 1'b0;
    endtask

    // Driver: queue the expected result, then walk the engine to finished.
    task automatic run_case(input int x, input int y);
        exp_q.push_back(ref_gcd(x, y));
        @(negedge clk);
        a_in = x[7:0];
        b_in = y[7:0];
        pulse_start();
        for (int i = 0; i < 200 && state_oh != 4'b1000; i++) pulse_step();
        check("R10 reached finished", state_oh, 4'b1000);
        pulse_start();
        check("R8 back to idle", state_oh, 4'b0001);
    endtask

    // Monitor: on each entry to finished, compare against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && state_oh == 4'b1000 && prev_state != 4'b1000) begin
            if (exp_q.size() == 0) check("R10 unexpected result", 1, 0);
            else check("R10 result", gcd_out, exp_q.pop_front());
        end
        prev_state <= state_oh;
    end

    initial begin
        #900000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 state", state_oh, 4'b0001);
        check("R1 a", a_q, 0);
        check("R1 gcd", gcd_out, 0);
        check("R1 cnt", pow2_cnt, 0);
        rst_n = 1'b1;

        // R2 step ignored in idle
        a_in = 8'd12; b_in = 8'd18;
        pulse_step();
        check("R2 step in idle", state_oh, 4'b0001);
        check("R2 step in idle a", a_q, 0);

        // Directed trace of 12 and 18
        exp_q.push_back(6);
        pulse_start();
        check("R2 load state", state_oh, 4'b0010);
        check("R2 load a", a_q, 12);
        check("R2 load b", b_q, 18);
        pulse_step();
        check("R5 both even a", a_q, 6);
        check("R5 both even b", b_q, 9);
        check("R5 both even cnt", pow2_cnt, 1);
        repeat (3) @(negedge clk);
        check("R4 no step a", a_q, 6);
        check("R4 no step b", b_q, 9);
        pulse_start();
        check("R9 start ignored state", state_oh, 4'b0010);
        check("R9 start ignored a", a_q, 6);
        pulse_step();
        check("R5 a even", a_q, 3);
        check("R5 a even b", b_q, 9);
        pulse_step();
        check("R5 subtract b", b_q, 6);
        pulse_step();
        check("R5 b even", b_q, 3);
        pulse_step();
        check("R6 restore state", state_oh, 4'b0100);
        check("R6 latch", gcd_out, 3);
        check("R6 cnt kept", pow2_cnt, 1);
        repeat (2) @(negedge clk);
        check("R4 restore hold", gcd_out, 3);
        pulse_step();
        check("R7 double", gcd_out, 6);
        check("R7 cnt dec", pow2_cnt, 0);
        pulse_step();
        check("R7 finished", state_oh, 4'b1000);
        check("R7 no change", gcd_out, 6);
        pulse_step();
        repeat (3) @(negedge clk);
        check("R8 hold state", state_oh, 4'b1000);
        check("R8 hold gcd", gcd_out, 6);
        pulse_start();
        check("R8 ack", state_oh, 4'b0001);

        // R3 zero operand
        exp_q.push_back(0);
        a_in = 8'd0; b_in = 8'd5;
        pulse_start();
        check("R3 finished", state_oh, 4'b1000);
        check("R3 zero result", gcd_out, 0);
        pulse_start();

        // R10 scoreboard runs
        run_case(255, 255);
        run_case(1, 255);
        run_case(128, 64);
        run_case(200, 150);
        run_case(17, 13);
        run_case(96, 36);
        run_case(254, 2);
        run_case(0, 0);
        run_case(7, 0);
        for (int k = 1; k < 16; k++) run_case((k * 37) % 256, (k * 91 + 24) % 256);

        check("R10 queue empty", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule